// File: doc/BRIEF.md
# Armable Timer Compare Channel

This block is one compare channel that watches a free-running 32-bit time count with an 8 µs tick. The count comes from outside the block. Software writes a compare value, and the write arms the channel. The value can be written on the 8 µs grid or at finer resolutions of 1 µs or 250 ns. A finer write is rounded to the nearest 8 µs tick before it is stored.

While the channel is armed, it fires when the count reaches the stored value. It also fires when the stored value lies less than a programmable past window behind the count. The default window is 125000 ticks, about one second. When it fires, the channel pulses a raw event, latches a raw interrupt flag and disarms itself. The flag sits in a small set/clear/mask interrupt group with a masked status output.

Reads return the stored value at the selected resolution, with the low bits zero. Disarming is done with a clear strobe. The matching arm strobe is accepted but has no effect on a compare channel.

Top module: `cmp_chan`

## Requirements
- R1: After reset, armed_o, raw_o, mask_o, mis_o and event_o are 0 and the stored compare value is 0.
- R2: A write with wr_cc_i[0] (the 8 µs grid) stores wdata_i unchanged, and armed_o reads 1 from the next cycle.
- R3: A write with wr_cc_i[1] (1 µs) stores (wdata_i+4)>>3. A write with wr_cc_i[2] (250 ns) stores (wdata_i+16)>>5. Both sums are computed in 33 bits, and both writes arm the channel. If several strobes are high, the lowest index wins.
- R4: rdata_o returns the stored value for rd_res_i=0 or 3, the value shifted left by 3 for rd_res_i=1, and the value shifted left by 5 for rd_res_i=2, all truncated to 32 bits.
- R5: event_o is high in every cycle where the channel is armed and (count_i − value) mod 2^32 is less than PAST_WIN. This includes an exact match and a count that has wrapped past zero.
- R6: After a cycle with event_o high, the channel is disarmed, unless a compare write happened in that same cycle.
- R7: arm_clr_i disarms the channel without an event. If a match happens in the same cycle, event_o still fires in that cycle.
- R8: arm_set_i has no effect on armed_o.
- R9: raw_o is set by an event or by irq_set_i. It is cleared by irq_clr_i or by any compare write. When a set and a clear happen in the same cycle, the set wins.
- R10: mask_set_i sets mask_o and mask_clr_i clears it, with set winning. mis_o equals raw_o AND mask_o.
- R11: A value that is PAST_WIN or more ticks behind the count, or any amount ahead of it, does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 32 | Time count on the 8 µs grid |
| wr_cc_i | input | 3 | Compare write strobes: bit 0 is 8 µs, bit 1 is 1 µs, bit 2 is 250 ns |
| wdata_i | input | 32 | Compare write data |
| rd_res_i | input | 2 | Read resolution select |
| arm_set_i | input | 1 | Arm strobe (no effect) |
| arm_clr_i | input | 1 | Disarm strobe |
| irq_set_i | input | 1 | Force the raw flag |
| irq_clr_i | input | 1 | Clear the raw flag |
| mask_set_i | input | 1 | Set the mask bit |
| mask_clr_i | input | 1 | Clear the mask bit |
| rdata_o | output | 32 | Compare value readback |
| armed_o | output | 1 | Channel armed |
| event_o | output | 1 | Raw compare event |
| raw_o | output | 1 | Raw interrupt flag |
| mask_o | output | 1 | Mask bit |
| mis_o | output | 1 | Masked interrupt status |

## Verification
The assertions check several rules on every cycle:
- an event only occurs while the channel is armed;
- a write arms the channel;
- a fire or a clear strobe leaves it disarmed;
- arm_set_i never arms it;
- the raw flag follows its set and clear rules;
- a mask clear blanks mis_o.

Other behaviour only the bench scenarios can show. This covers the rounding arithmetic at each resolution and the truncated readback. It also covers the exact edges of the past window, including the wrap around zero. The bench also checks that a disarm in a match cycle still produces the event, and that a compare write wipes a pending flag.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;
  localparam int unsigned NUM_RES = 3;

  typedef enum logic [1:0] {
    RES_8U   = 2'd0,
    RES_1U   = 2'd1,
    RES_250N = 2'd2,
    RES_ALT  = 2'd3
  } res_e;

  // right shift from the write resolution onto the 8 us grid
  function automatic int unsigned res_shift(int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/cmp_chan_conv.sv
module cmp_chan_conv #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SHIFT = 3
) (
  input  logic [CNT_W-1:0] raw_i,
  output logic [CNT_W-1:0] grid_o
);
  if (SHIFT == 0) begin : g_pass
    assign grid_o = raw_i;
  end else begin : g_round
    localparam logic [CNT_W:0] HALF = (CNT_W+1)'(1) << (SHIFT - 1);
    logic [CNT_W:0] sum;
    logic [CNT_W:0] shr;
    assign sum    = {1'b0, raw_i} + HALF;
    assign shr    = sum >> SHIFT;
    assign grid_o = shr[CNT_W-1:0];
  end
endmodule

// File: rtl/cmp_chan_core.sv
module cmp_chan_core #(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned PAST_WIN     = 125000,
  parameter bit          ARM_SET_ARMS = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             arm_set_i,
  input  logic             arm_clr_i,
  output logic [CNT_W-1:0] cc_o,
  output logic             armed_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] WIN = CNT_W'(PAST_WIN);

  logic [CNT_W-1:0] cc_q;
  logic [CNT_W-1:0] diff;
  logic             armed_q, armed_d, in_win;

  // modular distance of the count past the compare value
  assign diff    = count_i - cc_q;
  assign in_win  = diff < WIN;
  assign match_o = armed_q & in_win;

  always_comb begin
    armed_d = armed_q;
    if (arm_set_i && ARM_SET_ARMS) armed_d = 1'b1;
    if (match_o || arm_clr_i)      armed_d = 1'b0;
    if (load_i)                    armed_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      if (load_i) cc_q <= load_val_i;
    end
  end

  assign cc_o    = cc_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/cmp_chan_irq.sv
module cmp_chan_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic reload_i,
  input  logic mask_set_i,
  input  logic mask_clr_i,
  output logic raw_o,
  output logic mask_o,
  output logic mis_o
);
  logic raw_q, raw_d, mask_q, mask_d;

  always_comb begin
    raw_d = raw_q;
    if (clr_i || reload_i) raw_d = 1'b0;
    if (evt_i || set_i)    raw_d = 1'b1;
    mask_d = (mask_q & ~mask_clr_i) | mask_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign mis_o  = raw_q & mask_q;
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan
  import cmp_chan_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned PAST_WIN = 125000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    count_i,
  input  logic [NUM_RES-1:0]  wr_cc_i,
  input  logic [CNT_W-1:0]    wdata_i,
  input  logic [1:0]          rd_res_i,
  input  logic                arm_set_i,
  input  logic                arm_clr_i,
  input  logic                irq_set_i,
  input  logic                irq_clr_i,
  input  logic                mask_set_i,
  input  logic                mask_clr_i,
  output logic [CNT_W-1:0]    rdata_o,
  output logic                armed_o,
  output logic                event_o,
  output logic                raw_o,
  output logic                mask_o,
  output logic                mis_o
);
  localparam int unsigned SH_1U   = res_shift(1);
  localparam int unsigned SH_250N = res_shift(2);

  logic [CNT_W-1:0] grid [NUM_RES];
  logic [CNT_W-1:0] load_val, cc;
  logic             load, match;

  for (genvar i = 0; i < NUM_RES; i++) begin : g_conv
    cmp_chan_conv #(.CNT_W(CNT_W), .SHIFT(res_shift(i))) u_conv (
      .raw_i  (wdata_i),
      .grid_o (grid[i])
    );
  end

  // lowest strobe index wins
  always_comb begin
    load_val = grid[0];
    for (int i = NUM_RES - 1; i >= 0; i--)
      if (wr_cc_i[i]) load_val = grid[i];
  end
  assign load = |wr_cc_i;

  cmp_chan_core #(.CNT_W(CNT_W), .PAST_WIN(PAST_WIN)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (count_i),
    .load_i     (load),
    .load_val_i (load_val),
    .arm_set_i  (arm_set_i),
    .arm_clr_i  (arm_clr_i),
    .cc_o       (cc),
    .armed_o    (armed_o),
    .match_o    (match)
  );

  cmp_chan_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (match),
    .set_i      (irq_set_i),
    .clr_i      (irq_clr_i),
    .reload_i   (load),
    .mask_set_i (mask_set_i),
    .mask_clr_i (mask_clr_i),
    .raw_o      (raw_o),
    .mask_o     (mask_o),
    .mis_o      (mis_o)
  );

  always_comb begin
    case (res_e'(rd_res_i))
      RES_1U:   rdata_o = cc << SH_1U;
      RES_250N: rdata_o = cc << SH_250N;
      default:  rdata_o = cc;
    endcase
  end

  assign event_o = match;
endmodule

// File: rtl/cmp_chan_chk.sv
module cmp_chan_chk #(
  parameter int unsigned NRES = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NRES-1:0] wr_cc_i,
  input logic            arm_set_i,
  input logic            arm_clr_i,
  input logic            irq_set_i,
  input logic            irq_clr_i,
  input logic            mask_set_i,
  input logic            mask_clr_i,
  input logic            armed_o,
  input logic            event_o,
  input logic            raw_o,
  input logic            mis_o
);
  logic wr_any;
  assign wr_any = |wr_cc_i;

  p_write_arms_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> armed_o);

  p_evt_armed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> armed_o);

  p_fire_disarm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !wr_any) |=> !armed_o);

  p_clr_disarm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_clr_i && !wr_any) |=> !armed_o);

  p_set_noarm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_set_i && !armed_o && !wr_any) |=> !armed_o);

  p_raw_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o || irq_set_i) |=> raw_o);

  p_raw_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !irq_set_i && !event_o) |=> !raw_o);

  p_mask_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_clr_i && !mask_set_i) |=> !mis_o);
endmodule

bind cmp_chan cmp_chan_chk #(.NRES(cmp_chan_pkg::NUM_RES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_cc_i    (wr_cc_i),
  .arm_set_i  (arm_set_i),
  .arm_clr_i  (arm_clr_i),
  .irq_set_i  (irq_set_i),
  .irq_clr_i  (irq_clr_i),
  .mask_set_i (mask_set_i),
  .mask_clr_i (mask_clr_i),
  .armed_o    (armed_o),
  .event_o    (event_o),
  .raw_o      (raw_o),
  .mis_o      (mis_o)
);

// File: tb/cmp_chan_bench.sv
module cmp_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] count = '0;
  logic [2:0]  wr_cc = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  rd_res = '0;
  logic        arm_set = 0, arm_clr = 0, irq_set = 0, irq_clr = 0;
  logic        mask_set = 0, mask_clr = 0;
  logic [31:0] rdata;
  logic        armed, evt, raw, mask, mis;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  cmp_chan u_cmp_chan (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .wr_cc_i(wr_cc),
    .wdata_i(wdata), .rd_res_i(rd_res), .arm_set_i(arm_set),
    .arm_clr_i(arm_clr), .irq_set_i(irq_set), .irq_clr_i(irq_clr),
    .mask_set_i(mask_set), .mask_clr_i(mask_clr), .rdata_o(rdata),
    .armed_o(armed), .event_o(evt), .raw_o(raw), .mask_o(mask), .mis_o(mis)
  );

  typedef struct packed {
    logic [1:0]  res;
    logic [31:0] wdata;
    logic [31:0] cnt;
    logic [31:0] exp_cc;
    logic        exp_evt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'd100,          32'd100,          32'd100,          1'b1},
    '{2'd0, 32'd100,          32'd99,           32'd100,          1'b0},
    '{2'd0, 32'd100,          32'd125099,       32'd100,          1'b1},
    '{2'd0, 32'd100,          32'd125100,       32'd100,          1'b0},
    '{2'd1, 32'd803,          32'd100,          32'd100,          1'b1},
    '{2'd1, 32'd804,          32'd100,          32'd101,          1'b0},
    '{2'd2, 32'd3215,         32'd0,            32'd100,          1'b0},
    '{2'd2, 32'd3216,         32'd101,          32'd101,          1'b1},
    '{2'd0, 32'hFFFF_FFF0,    32'd5,            32'hFFFF_FFF0,    1'b1},
    '{2'd1, 32'hFFFF_FFFF,    32'h2000_0000,    32'h2000_0000,    1'b1},
    '{2'd0, 32'h8000_0000,    32'd0,            32'h8000_0000,    1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    wr_cc = '0; arm_set = 0; arm_clr = 0; irq_set = 0; irq_clr = 0;
    mask_set = 0; mask_clr = 0;
    #1;
  endtask

  task automatic write_cc(int res, logic [31:0] val);
    @(negedge clk);
    wdata = val;
    wr_cc = 3'(1 << res);
    step();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 armed", 32'(armed), 0);
    check("R1 raw", 32'(raw), 0);
    check("R1 mis", 32'(mis), 0);
    check("R1 mask", 32'(mask), 0);
    check("R1 event", 32'(evt), 0);
    check("R1 value", rdata, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table: R2 R3 R5 R11
    for (int i = 0; i < NV; i++) begin
      count = VECS[i].cnt;
      rd_res = 2'd0;
      write_cc(int'(VECS[i].res), VECS[i].wdata);
      check($sformatf("R3 vec%0d stored", i), rdata, VECS[i].exp_cc);
      check($sformatf("R5/R11 vec%0d event", i), 32'(evt), 32'(VECS[i].exp_evt));
      arm_clr = 1; irq_clr = 1;
      step();
    end

    // R2 R4 readback at each resolution
    count = 32'd0;
    write_cc(0, 32'h1234_5678);
    check("R2 armed", 32'(armed), 1);
    rd_res = 2'd1; #1 check("R4 rd 1us", rdata, 32'h91A2_B3C0);
    rd_res = 2'd2; #1 check("R4 rd 250ns", rdata, 32'h468A_CF00);
    rd_res = 2'd3; #1 check("R4 rd alt", rdata, 32'h1234_5678);
    rd_res = 2'd0;

    // R5 R6 fire then disarm
    write_cc(0, 32'd50);
    check("R5 no early event", 32'(evt), 0);
    @(negedge clk); count = 32'd50; #1;
    check("R5 match event", 32'(evt), 1);
    step();
    check("R6 disarmed", 32'(armed), 0);
    check("R6 event drops", 32'(evt), 0);
    check("R9 raw on event", 32'(raw), 1);

    // R10 mask
    check("R10 mis masked", 32'(mis), 0);
    mask_set = 1; step();
    check("R10 mask set", 32'(mask), 1);
    check("R10 mis", 32'(mis), 1);
    mask_clr = 1; step();
    check("R10 mis cleared", 32'(mis), 0);

    // R9 raw flag control
    irq_clr = 1; step();
    check("R9 irq clr", 32'(raw), 0);
    irq_set = 1; step();
    check("R9 irq set", 32'(raw), 1);
    irq_set = 1; irq_clr = 1; step();
    check("R9 set wins", 32'(raw), 1);
    write_cc(0, 32'h4000_0000);
    check("R9 write clears", 32'(raw), 0);
    check("R11 future no event", 32'(evt), 0);
    arm_clr = 1; step();

    // R7 disarm in match cycle still fires
    count = 32'd0;
    write_cc(0, 32'd200);
    @(negedge clk); count = 32'd200; arm_clr = 1; #1;
    check("R7 event with clear", 32'(evt), 1);
    step();
    check("R7 disarmed", 32'(armed), 0);
    check("R7 raw set", 32'(raw), 1);
    count = 32'd0;
    write_cc(0, 32'd300);
    check("R9 write clears pending", 32'(raw), 0);
    arm_clr = 1; step();
    check("R7 clr disarms", 32'(armed), 0);
    count = 32'd300; #1;
    check("R7 no event after clr", 32'(evt), 0);
    step();
    check("R7 raw stays clear", 32'(raw), 0);

    // R8 arm set has no effect
    arm_set = 1; step();
    check("R8 still disarmed", 32'(armed), 0);
    check("R8 no event", 32'(evt), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule